// File: doc/BRIEF.md
# QPSK Hard-Decision Receiver with Bit-Error Tally

This block sits at the end of a QPSK baseband test link. It accepts one signed I/Q sample per valid strobe and decides which quadrant the sample lies in. That decision gives back the two transmitted bits. The block then compares these bits against the reference bits that the transmitter produced for the same symbol and keeps a running count of compared bits and of bits in error.

The reference pair enters the block earlier than its symbol, because it skips the modulator and the channel. A delay line holds it back by exactly the upstream lag plus the one register of the slicer, so each comparison pairs a decision with its own reference. The block does no carrier or phase recovery. A rotated constellation therefore shows up only as a rising error count.

Top module: `qpsk_hd_rx_ber`

## Requirements
- R1: The decision is taken from the signs alone, with zero counted as positive. Bit 0 of `dec_bits` is 1 exactly when I is negative, and bit 1 is 1 exactly when Q is negative. This gives (+,+)→00, (−,+)→01, (−,−)→11 and (+,−)→10.
- R2: A symbol presented with `sym_valid` high at a rising edge appears on `dec_bits` after that edge. `dec_valid` is high for exactly the cycle that follows each valid symbol.
- R3: While `sym_valid` is low, the I/Q inputs are ignored and `dec_bits` keeps its last decision.
- R4: The reference pair given with `ref_valid` is compared against the decision of the symbol that arrives `SYM_LAG` cycles later. The input contract is that `sym_valid` equals `ref_valid` delayed by `SYM_LAG` cycles.
- R5: Each compared symbol adds 2 to `bits_total`.
- R6: Each compared symbol adds the number of set bits in (reference XOR decision) to `bits_errored`, which is 0, 1 or 2. `bits_errored` never exceeds `bits_total`.
- R7: The counters change only for compared symbols. They are updated on the edge after the one that updates `dec_bits`.
- R8: Both counters saturate at all-ones and never wrap.
- R9: Reset (active low, asynchronous) clears `dec_bits`, `dec_valid` and both counters.
- R10: A channel without rotation adds no errors. A 180-degree rotation makes every compared bit an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ref_valid | input | 1 | Reference pair present |
| ref_bits | input | 2 | Transmitted bit pair |
| sym_valid | input | 1 | Received symbol present |
| sym_i | input | IQ_W | Signed in-phase sample |
| sym_q | input | IQ_W | Signed quadrature sample |
| dec_bits | output | 2 | Decided bit pair |
| dec_valid | output | 1 | Decision pulse |
| bits_total | output | CNT_W | Compared-bit count |
| bits_errored | output | CNT_W | Errored-bit count |

## Verification
The alignment assertion assumes that the source keeps to the lag contract: every reference strobe is followed by its symbol strobe exactly `SYM_LAG` cycles later. The bench builds each symbol strobe from its own record of the reference strobes it drove, so it never breaks that contract. The bench fills idle cycles with changing I/Q values so that ignored inputs are actually exercised. It also sweeps every I/Q code of a 4-bit build and runs all four rotations against a small-counter copy of the block, which saturates early.

// File: rtl/qpsk_rx_pkg.sv
package qpsk_rx_pkg;

  typedef logic [1:0] dibit_t;

  localparam int unsigned DEC_LATENCY = 1;

  function automatic dibit_t quadrant_bits(input logic i_neg, input logic q_neg);
    return {q_neg, i_neg};
  endfunction

  function automatic logic [1:0] pair_weight(input dibit_t d);
    return {1'b0, d[0]} + {1'b0, d[1]};
  endfunction

endpackage

// File: rtl/qpsk_quadrant_slicer.sv
module qpsk_quadrant_slicer
  import qpsk_rx_pkg::*;
#(
  parameter int unsigned IQ_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [IQ_W-1:0] in_i,
  input  logic signed [IQ_W-1:0] in_q,
  output dibit_t                 out_bits,
  output logic                   out_valid
);

  dibit_t bits_d, bits_q;
  logic   valid_d, valid_q;

  always_comb begin
    bits_d  = bits_q;
    valid_d = in_valid;
    if (in_valid) begin
      bits_d = quadrant_bits(in_i < 0, in_q < 0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      bits_q  <= bits_d;
      valid_q <= valid_d;
    end
  end

  assign out_bits  = bits_q;
  assign out_valid = valid_q;

  assert_dec_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_bits));

  assert_first_quadrant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_i >= 0 && in_q >= 0) |=> out_bits == 2'b00);

  assert_third_quadrant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_i < 0 && in_q < 0) |=> out_bits == 2'b11);

endmodule

// File: rtl/qpsk_ref_align.sv
module qpsk_ref_align
  import qpsk_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  dibit_t in_bits,
  output logic   out_valid,
  output dibit_t out_bits
);

  logic   vld_d  [DEPTH];
  logic   vld_q  [DEPTH];
  dibit_t bits_d [DEPTH];
  dibit_t bits_q [DEPTH];

  always_comb begin
    vld_d[0]  = in_valid;
    bits_d[0] = in_valid ? in_bits : bits_q[0];
    for (int k = 1; k < DEPTH; k++) begin
      vld_d[k]  = vld_q[k-1];
      bits_d[k] = vld_q[k-1] ? bits_q[k-1] : bits_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        vld_q[k]  <= 1'b0;
        bits_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        vld_q[k]  <= vld_d[k];
        bits_q[k] <= bits_d[k];
      end
    end
  end

  assign out_valid = vld_q[DEPTH-1];
  assign out_bits  = bits_q[DEPTH-1];

endmodule

// File: rtl/qpsk_sat_acc.sv
module qpsk_sat_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   inc,
  output logic [W-1:0] acc
);

  logic [W:0]   sum;
  logic [W-1:0] acc_d, acc_q;

  always_comb begin
    sum   = {1'b0, acc_q} + {{(W-1){1'b0}}, inc};
    acc_d = acc_q;
    if (en) begin
      acc_d = sum[W] ? {W{1'b1}} : sum[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  assert_acc_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q >= $past(acc_q));

  assert_acc_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));

endmodule

// File: rtl/qpsk_hd_rx_ber.sv
module qpsk_hd_rx_ber
  import qpsk_rx_pkg::*;
#(
  parameter int unsigned IQ_W    = 16,
  parameter int unsigned SYM_LAG = 2,
  parameter int unsigned CNT_W   = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ref_valid,
  input  logic [1:0]             ref_bits,
  input  logic                   sym_valid,
  input  logic signed [IQ_W-1:0] sym_i,
  input  logic signed [IQ_W-1:0] sym_q,
  output logic [1:0]             dec_bits,
  output logic                   dec_valid,
  output logic [CNT_W-1:0]       bits_total,
  output logic [CNT_W-1:0]       bits_errored
);

  localparam int unsigned REF_DEPTH = SYM_LAG + DEC_LATENCY;

  dibit_t     slice_bits;
  logic       slice_valid;
  dibit_t     ref_al_bits;
  logic       ref_al_valid;
  logic       cmp_en;
  logic [1:0] err_inc;

  qpsk_quadrant_slicer #(.IQ_W(IQ_W)) slicer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (sym_valid),
    .in_i      (sym_i),
    .in_q      (sym_q),
    .out_bits  (slice_bits),
    .out_valid (slice_valid)
  );

  qpsk_ref_align #(.DEPTH(REF_DEPTH)) align_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (ref_valid),
    .in_bits   (ref_bits),
    .out_valid (ref_al_valid),
    .out_bits  (ref_al_bits)
  );

  always_comb begin
    cmp_en  = slice_valid & ref_al_valid;
    err_inc = pair_weight(slice_bits ^ ref_al_bits);
  end

  qpsk_sat_acc #(.W(CNT_W)) total_acc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cmp_en),
    .inc   (2'd2),
    .acc   (bits_total)
  );

  qpsk_sat_acc #(.W(CNT_W)) error_acc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cmp_en),
    .inc   (err_inc),
    .acc   (bits_errored)
  );

  assign dec_bits  = slice_bits;
  assign dec_valid = slice_valid;

  assert_ref_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slice_valid == ref_al_valid);

  assert_err_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bits_errored <= bits_total);

  assert_dec_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> !dec_valid);

endmodule

// File: tb/qpsk_hd_rx_ber_tb_top.sv
`timescale 1ns/1ps
module qpsk_hd_rx_ber_tb_top;

  localparam int IQ_W = 4;
  localparam int LAG  = 2;
  localparam int CW   = 32;
  localparam int SW   = 5;
  localparam int SMAX = 31;
  localparam int HN   = 2048;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                   rst_n;
  logic                   ref_valid;
  logic [1:0]             ref_bits;
  logic                   sym_valid;
  logic signed [IQ_W-1:0] sym_i, sym_q;
  logic [1:0]             dec_bits, dec_bits_s;
  logic                   dec_valid, dec_valid_s;
  logic [CW-1:0]          tot, err;
  logic [SW-1:0]          tot_s, err_s;

  qpsk_hd_rx_ber #(.IQ_W(IQ_W), .SYM_LAG(LAG), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_bits(ref_bits),
    .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q),
    .dec_bits(dec_bits), .dec_valid(dec_valid),
    .bits_total(tot), .bits_errored(err));

  qpsk_hd_rx_ber #(.IQ_W(IQ_W), .SYM_LAG(LAG), .CNT_W(SW)) dut_sat_i (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_bits(ref_bits),
    .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q),
    .dec_bits(dec_bits_s), .dec_valid(dec_valid_s),
    .bits_total(tot_s), .bits_errored(err_s));

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  logic       rv_h [HN];
  logic [1:0] rb_h [HN];
  logic [7:0] sw_idx = 8'd0;
  logic [1:0] last_dec = 2'b00;
  int exp_tot = 0, exp_err = 0, exp_tot_s = 0, exp_err_s = 0;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int sat(input int v);
    return (v > SMAX) ? SMAX : v;
  endfunction

  // mode 0: symbol = rotated Gray point of its reference; mode 1: raw sweep code
  task automatic step(input logic rv, input logic [1:0] rb, input int mode, input int rot);
    logic       sv;
    logic [1:0] rf, expd;
    int         pi, pq, ri, rq, e;
    rv_h[cyc] = rv;
    rb_h[cyc] = rb;
    sv = (cyc >= LAG) ? rv_h[cyc-LAG] : 1'b0;
    rf = (cyc >= LAG) ? rb_h[cyc-LAG] : 2'b00;
    if (sv && mode == 0) begin
      pi = rf[0] ? -5 : 5;
      pq = rf[1] ? -5 : 5;
      case (rot)
        1:       begin ri = -pq; rq = pi;  end
        2:       begin ri = -pi; rq = -pq; end
        3:       begin ri = pq;  rq = -pi; end
        default: begin ri = pi;  rq = pq;  end
      endcase
    end else if (sv) begin
      ri = $signed(sw_idx[7:4]);
      rq = $signed(sw_idx[3:0]);
      sw_idx = sw_idx + 8'd1;
    end else begin
      ri = (cyc % 16) - 8;
      rq = 7 - (cyc % 16);
    end
    ref_valid = rv;
    ref_bits  = rb;
    sym_valid = sv;
    sym_i     = 4'(ri);
    sym_q     = 4'(rq);
    @(posedge clk);
    @(negedge clk);
    check("R2 dec_valid", int'(dec_valid), int'(sv));
    if (sv) begin
      expd = {rq < 0, ri < 0};
      check("R1 dec_bits", int'(dec_bits), int'(expd));
      last_dec = expd;
    end else begin
      check("R3 dec_bits held", int'(dec_bits), int'(last_dec));
    end
    check("R5 R7 bits_total", int'(tot), exp_tot);
    check("R6 R7 bits_errored", int'(err), exp_err);
    check("R8 saturating total", int'(tot_s), exp_tot_s);
    check("R8 saturating errors", int'(err_s), exp_err_s);
    if (sv) begin
      e = int'(expd[0] ^ rf[0]) + int'(expd[1] ^ rf[1]);
      exp_tot   += 2;
      exp_err   += e;
      exp_tot_s = sat(exp_tot_s + 2);
      exp_err_s = sat(exp_err_s + e);
    end
    cyc++;
  endtask

  task automatic run_rot(input int rot, input int n, output int d_tot, output int d_err);
    int t0, e0;
    t0 = int'(tot);
    e0 = int'(err);
    for (int k = 0; k < n; k++) begin
      step((cyc % 5) != 3, 2'((cyc * 3) ^ (cyc >> 2)), 0, rot);
    end
    for (int k = 0; k < LAG + 2; k++) step(1'b0, 2'b00, 0, rot);
    d_tot = int'(tot) - t0;
    d_err = int'(err) - e0;
  endtask

  logic done = 1'b0;

  initial begin
    int dt, de;
    rst_n = 1'b0;
    ref_valid = 1'b0; ref_bits = 2'b00; sym_valid = 1'b0;
    sym_i = '0; sym_q = '0;
    repeat (3) @(negedge clk);
    check("R9 reset dec_valid", int'(dec_valid), 0);
    check("R9 reset dec_bits", int'(dec_bits), 0);
    check("R9 reset total", int'(tot), 0);
    check("R9 reset errors", int'(err), 0);
    rst_n = 1'b1;

    run_rot(0, 60, dt, de);
    check("R10 no rotation error delta", de, 0);
    check("R5 rotation-0 bits compared", (dt > 0) ? 1 : 0, 1);
    run_rot(2, 60, dt, de);
    check("R10 half-turn errors equal compared bits", de, dt);
    run_rot(1, 30, dt, de);
    run_rot(3, 30, dt, de);

    for (int k = 0; k < 256 + LAG; k++) step(1'b1, 2'(k ^ (k >> 3)), 1, 0);
    for (int k = 0; k < LAG + 2; k++) step(1'b0, 2'b00, 1, 0);
    check("R4 sweep compared bits", int'(tot), exp_tot);

    rst_n = 1'b0;
    #1;
    check("R9 async reset total", int'(tot), 0);
    check("R9 async reset errors", int'(err), 0);
    check("R9 async reset sat total", int'(tot_s), 0);
    check("R9 async reset dec_bits", int'(dec_bits), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule